// File: doc/BRIEF.md
# I2C Register Target with Per-Byte CRC-8

This block is a bus target for a two-wire serial bus. It runs from a fast system clock that oversamples SCL and SDA, and it gives an external controller access to a byte-wide register file through a simple read port and a write port. The controller first writes a register pointer. It then either streams data bytes into consecutive registers, or starts a read and streams bytes back from consecutive registers. The read may follow a repeated START, or it may come as a separate transaction after a STOP.

The target can protect every data byte with an 8-bit CRC (polynomial 0x07, seed 0x00, MSB first). The CRC setting is off after reset. A write to the CRC setting is held as pending and takes effect only when the config-exit strobe arrives. On a write, the target answers a CRC byte that does not match with NACK and then ignores the bus until the next START. A programmable SCL-low timeout returns the protocol logic to idle and releases SDA.

SDA is open drain. `sda_oe` high means the target pulls the line low.

Top module: `i2c_crc_target`

## Requirements
- R1: The first byte after a START is matched on bits [7:1] against `dev_addr`, and bit 0 selects write (0) or read (1). On a match the target ACKs by pulling SDA low during the 9th clock. On a mismatch it never pulls SDA low and ignores every byte until the next START.
- R2: In a write, the byte after the address sets the register pointer. Each accepted data byte after that produces a one-cycle `wr_en` pulse carrying `wr_addr` = pointer and `wr_data` = the byte, and then the pointer increments by one. Any number of data bytes may come before the STOP.
- R3: In a read, the target sends the byte at `rd_addr` = pointer, MSB first, and increments the pointer for each byte sent. It keeps sending while the controller ACKs. A controller NACK ends the read: SDA is released and the target goes idle.
- R4: A read returns data from the last written pointer. This holds when the read address follows a repeated START, and also when it follows a STOP and a fresh START.
- R5: CRC mode is off after reset. A `cfg_crc_wr` pulse stores `cfg_crc_val` as pending and does not change the active mode. Only a `cfg_exit` pulse copies the pending value into the active mode.
- R6: With CRC on, a CRC byte follows every write data byte. The first one covers the address byte, the pointer byte and the first data byte. Each later one covers only its own data byte, starting from 0x00. A data byte is written only once its CRC byte has been accepted.
- R7: With CRC on, if a received CRC byte does not match, the target NACKs it, writes nothing, and ignores every later byte until the next START.
- R8: With CRC on, the target sends a CRC byte after every read data byte. The first one covers the read address byte and the first data byte. Each later one covers only its data byte. A controller NACK on a CRC byte sends the target to idle.
- R9: While a transaction is active, if SCL stays low for `to_limit` consecutive system clocks and `to_limit` is not 0, the target goes idle and releases SDA. A `to_limit` of 0 disables the timeout.
- R10: A STOP returns the target to idle with SDA released, and SDA is released after reset. The target changes SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | High to pull SDA low |
| dev_addr | input | 7 | Target bus address |
| to_limit | input | TW | SCL-low timeout in system clocks, 0 = off |
| cfg_crc_wr | input | 1 | Strobe that stores a pending CRC mode |
| cfg_crc_val | input | 1 | Pending CRC mode value (1 = on) |
| cfg_exit | input | 1 | Strobe that applies the pending CRC mode |
| rd_addr | output | 8 | Register read address (the pointer) |
| rd_data | input | 8 | Register read data for `rd_addr` |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Register write address |
| wr_data | output | 8 | Register write data |

## Verification
The assertions check, on every cycle, the following properties:
- SDA never changes while SCL is high.
- The write strobe is never longer than one cycle.
- The active CRC mode never changes without the exit strobe.
- Both STOP and an expired timeout leave SDA released.

Only the bench scenarios can show the rest. These are:
- which bytes each CRC covers, and its reseeding between bytes;
- that a write is deferred until its CRC byte is accepted;
- the silence after a rejected CRC or a foreign address;
- pointer progression across block transfers;
- the equivalence of the repeated-START read and the STOP-then-START read.

// File: rtl/i2c_crc_target.sv
module i2c_crc_target #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [6:0]    dev_addr,
  input  logic [TW-1:0] to_limit,
  input  logic          cfg_crc_wr,
  input  logic          cfg_crc_val,
  input  logic          cfg_exit,
  output logic [7:0]    rd_addr,
  input  logic [7:0]    rd_data,
  output logic          wr_en,
  output logic [7:0]    wr_addr,
  output logic [7:0]    wr_data
);

  typedef enum logic [1:0] {IDLE, RX, TX} st_t;
  typedef enum logic [2:0] {K_ADDR, K_PTR, K_WDAT, K_WCRC, K_RDAT, K_RCRC} kind_t;

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++)
      r = r[7] ? ({r[6:0], 1'b0} ^ 8'h07) : {r[6:0], 1'b0};
    return r;
  endfunction

  logic [2:0]    scl_q, sda_q;
  st_t           st;
  kind_t         kind;
  logic [3:0]    bcnt;
  logic [7:0]    sh, tx, ptr, crc, wbuf;
  logic          mack, rw, crc_on, crc_pend;
  logic [TW-1:0] tcnt;

  wire scl_s = scl_q[1];
  wire scl_p = scl_q[2];
  wire sda_s = sda_q[1];
  wire sda_p = sda_q[2];

  wire rise     = scl_s & ~scl_p;
  wire fall     = ~scl_s & scl_p;
  wire start_ev = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
  wire tmo      = (to_limit != '0) && (tcnt >= to_limit);

  assign rd_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_on   <= 1'b0;
      crc_pend <= 1'b0;
    end else begin
      if (cfg_crc_wr) crc_pend <= cfg_crc_val;
      if (cfg_exit)   crc_on   <= crc_pend;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tcnt <= '0;
    else if (st == IDLE || scl_s)
      tcnt <= '0;
    else if (tcnt != '1)
      tcnt <= tcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      kind    <= K_ADDR;
      bcnt    <= '0;
      sh      <= '0;
      tx      <= '0;
      ptr     <= '0;
      crc     <= '0;
      wbuf    <= '0;
      mack    <= 1'b0;
      rw      <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_ev) begin
        st     <= RX;
        kind   <= K_ADDR;
        bcnt   <= '0;
        crc    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_ev || tmo) begin
        st     <= IDLE;
        sda_oe <= 1'b0;
      end else if (st == RX) begin
        if (rise && bcnt < 4'd8) begin
          sh   <= {sh[6:0], sda_s};
          bcnt <= bcnt + 4'd1;
        end else if (rise) begin
          bcnt <= 4'd9;
        end
        if (fall && bcnt == 4'd8) begin
          case (kind)
            K_ADDR: begin
              if (sh[7:1] == dev_addr) begin
                sda_oe <= 1'b1;
                rw     <= sh[0];
                crc    <= crc8(crc, sh);
              end else begin
                st <= IDLE;
              end
            end
            K_PTR: begin
              sda_oe <= 1'b1;
              ptr    <= sh;
              crc    <= crc8(crc, sh);
            end
            K_WDAT: begin
              sda_oe <= 1'b1;
              crc    <= crc8(crc, sh);
              if (crc_on) begin
                wbuf <= sh;
              end else begin
                wr_en   <= 1'b1;
                wr_addr <= ptr;
                wr_data <= sh;
                ptr     <= ptr + 8'd1;
              end
            end
            K_WCRC: begin
              if (sh == crc) begin
                sda_oe  <= 1'b1;
                wr_en   <= 1'b1;
                wr_addr <= ptr;
                wr_data <= wbuf;
                ptr     <= ptr + 8'd1;
                crc     <= '0;
              end else begin
                st <= IDLE;
              end
            end
            default: st <= IDLE;
          endcase
        end
        if (fall && bcnt == 4'd9) begin
          sda_oe <= 1'b0;
          bcnt   <= '0;
          case (kind)
            K_ADDR: begin
              if (rw) begin
                st     <= TX;
                kind   <= K_RDAT;
                tx     <= rd_data;
                sda_oe <= ~rd_data[7];
                ptr    <= ptr + 8'd1;
                crc    <= crc8(crc, rd_data);
              end else begin
                kind <= K_PTR;
              end
            end
            K_PTR:   kind <= K_WDAT;
            K_WDAT:  kind <= crc_on ? K_WCRC : K_WDAT;
            default: kind <= K_WDAT;
          endcase
        end
      end else if (st == TX) begin
        if (rise && bcnt < 4'd8) begin
          bcnt <= bcnt + 4'd1;
        end else if (rise) begin
          mack <= ~sda_s;
          bcnt <= 4'd9;
        end
        if (fall && bcnt >= 4'd1 && bcnt <= 4'd7) begin
          sda_oe <= ~tx[6];
          tx     <= {tx[6:0], 1'b0};
        end
        if (fall && bcnt == 4'd8)
          sda_oe <= 1'b0;
        if (fall && bcnt == 4'd9) begin
          bcnt   <= '0;
          sda_oe <= 1'b0;
          if (!mack) begin
            st <= IDLE;
          end else if (kind == K_RDAT && crc_on) begin
            kind   <= K_RCRC;
            tx     <= crc;
            sda_oe <= ~crc[7];
            crc    <= '0;
          end else begin
            kind   <= K_RDAT;
            tx     <= rd_data;
            sda_oe <= ~rd_data[7];
            ptr    <= ptr + 8'd1;
            crc    <= crc8(crc, rd_data);
          end
        end
      end
    end
  end

endmodule

// File: rtl/i2c_crc_target_chk.sv
module i2c_crc_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic wr_en,
  input logic cfg_exit,
  input logic crc_on,
  input logic stop_ev,
  input logic tmo
);

  // R10
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  // R9
  timeout_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> !sda_oe);

  // R2
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R5
  crc_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_exit |=> $stable(crc_on));

endmodule

bind i2c_crc_target i2c_crc_target_chk chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .wr_en(wr_en),
  .cfg_exit(cfg_exit), .crc_on(crc_on), .stop_ev(stop_ev), .tmo(tmo)
);

// File: tb/i2c_crc_target_test.sv
module i2c_crc_target_test;
  localparam int Q = 30;
  localparam logic [15:0] VEC [0:5] = '{16'h0311, 16'h04A5, 16'h7F00,
                                        16'hFFFF, 16'h10C3, 16'h815A};

  logic clk = 0, rst_n = 0, scl = 1, m_sda = 1;
  logic [6:0] dev_addr = 7'h08;
  logic [15:0] to_limit = 16'd0;
  logic cfg_crc_wr = 0, cfg_crc_val = 0, cfg_exit = 0;
  logic sda_oe, wr_en;
  logic [7:0] rd_addr, wr_addr, wr_data;
  logic [7:0] mem [256];
  logic [7:0] d, c;
  int nchk = 0, nerr = 0;

  wire sda_bus = m_sda & ~sda_oe;
  wire [7:0] rd_data = mem[rd_addr];

  always #5 clk = ~clk;

  always @(posedge clk) if (wr_en) mem[wr_addr] <= wr_data;

  i2c_crc_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .dev_addr(dev_addr), .to_limit(to_limit), .cfg_crc_wr(cfg_crc_wr),
    .cfg_crc_val(cfg_crc_val), .cfg_exit(cfg_exit), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [7:0] bcrc(input logic [7:0] s, input logic [7:0] b);
    logic fb;
    for (int i = 7; i >= 0; i--) begin
      fb = s[7] ^ b[i];
      s = {s[6:0], 1'b0};
      if (fb) s = s ^ 8'h07;
    end
    return s;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic i2c_start;
    m_sda = 1; tick(Q); scl = 1; tick(Q); m_sda = 0; tick(Q); scl = 0; tick(Q);
  endtask

  task automatic i2c_stop;
    m_sda = 0; tick(Q); scl = 1; tick(Q); m_sda = 1; tick(Q);
  endtask

  task automatic wb(input logic [7:0] b, input logic exp_ack, input string req);
    logic a;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q); scl = 1; tick(2 * Q); scl = 0; tick(Q);
    end
    m_sda = 1; tick(Q); scl = 1; tick(Q);
    @(negedge clk) a = ~sda_bus;
    tick(Q); scl = 0; tick(Q);
    check({req, " ack"}, a, exp_ack);
  endtask

  task automatic rb(output logic [7:0] b, input logic ack);
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1; tick(Q);
      @(negedge clk) b[i] = sda_bus;
      tick(Q); scl = 0; tick(Q);
    end
    m_sda = ~ack; tick(Q); scl = 1; tick(2 * Q); scl = 0; tick(Q); m_sda = 1;
  endtask

  task automatic crc_cfg(input logic v);
    @(negedge clk) cfg_crc_wr = 1; cfg_crc_val = v;
    @(negedge clk) cfg_crc_wr = 0;
  endtask

  task automatic crc_exit;
    @(negedge clk) cfg_exit = 1;
    @(negedge clk) cfg_exit = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    tick(4);
    rst_n = 1;
    tick(4);
    @(negedge clk);
    check("R10 reset sda", sda_oe, 0);
    check("R10 reset wr", wr_en, 0);

    // R2 / R4 vector table: single write, then repeated-start read
    for (int i = 0; i < 6; i++) begin
      i2c_start; wb(8'h10, 1, "R1"); wb(VEC[i][15:8], 1, "R2"); wb(VEC[i][7:0], 1, "R2"); i2c_stop;
      check("R2 mem", mem[VEC[i][15:8]], VEC[i][7:0]);
      i2c_start; wb(8'h10, 1, "R1"); wb(VEC[i][15:8], 1, "R4");
      i2c_start; wb(8'h11, 1, "R4"); rb(d, 0); i2c_stop;
      check("R4 rs read", d, VEC[i][7:0]);
    end

    // R2 block write, R3/R4 block read with stop+start
    i2c_start; wb(8'h10, 1, "R1"); wb(8'h20, 1, "R2");
    for (int i = 0; i < 4; i++) wb(8'hD1 + 8'(i), 1, "R2");
    i2c_stop;
    for (int i = 0; i < 4; i++) check("R2 block mem", mem[8'h20 + i], 8'hD1 + i);
    i2c_start; wb(8'h10, 1, "R1"); wb(8'h20, 1, "R4"); i2c_stop;
    i2c_start; wb(8'h11, 1, "R4");
    for (int i = 0; i < 4; i++) begin
      rb(d, i != 3);
      check("R3 block read", d, 8'hD1 + i);
    end
    @(negedge clk) check("R3 released after nack", sda_oe, 0);
    i2c_stop;
    @(negedge clk) check("R10 released after stop", sda_oe, 0);

    // R1 foreign address ignored
    i2c_start; wb(8'h22, 0, "R1"); wb(8'h05, 0, "R1"); wb(8'hAA, 0, "R1"); i2c_stop;
    check("R1 no write", mem[5], 0);

    // R1 programmable address
    dev_addr = 7'h35;
    i2c_start; wb(8'h6A, 1, "R1"); wb(8'h08, 1, "R1"); wb(8'h99, 1, "R1"); i2c_stop;
    check("R1 new addr write", mem[8], 8'h99);
    i2c_start; wb(8'h10, 0, "R1 old addr"); i2c_stop;
    dev_addr = 7'h08;

    // R9 timeout releases a driven data bit
    to_limit = 16'd100;
    i2c_start; wb(8'h10, 1, "R1"); wb(8'h60, 1, "R9"); i2c_stop;
    i2c_start; wb(8'h11, 1, "R9");
    tick(4);
    @(negedge clk) check("R9 driving bit", sda_oe, 1);
    tick(200);
    @(negedge clk) check("R9 timeout release", sda_oe, 0);
    rb(d, 0); check("R9 idle after timeout", d, 8'hFF);
    i2c_stop;
    to_limit = 16'd0;
    i2c_start; wb(8'h10, 1, "R1"); wb(8'h60, 1, "R9"); i2c_stop;
    i2c_start; wb(8'h11, 1, "R9");
    tick(300);
    @(negedge clk) check("R9 disabled holds", sda_oe, 1);
    rb(d, 0); check("R9 disabled data", d, 8'h00);
    i2c_stop;

    // R5 pending mode has no effect before exit
    crc_cfg(1);
    i2c_start; wb(8'h10, 1, "R1"); wb(8'h30, 1, "R5"); wb(8'h11, 1, "R5"); wb(8'h22, 1, "R5"); i2c_stop;
    check("R5 still plain 1", mem[8'h30], 8'h11);
    check("R5 still plain 2", mem[8'h31], 8'h22);
    crc_exit;

    // R6 CRC write
    i2c_start; wb(8'h10, 1, "R1"); wb(8'h40, 1, "R6"); wb(8'h5A, 1, "R6");
    check("R6 deferred", mem[8'h40], 0);
    c = bcrc(bcrc(bcrc(8'h00, 8'h10), 8'h40), 8'h5A);
    wb(c, 1, "R6 first crc");
    wb(8'hC3, 1, "R6"); wb(bcrc(8'h00, 8'hC3), 1, "R6 second crc");
    i2c_stop;
    check("R6 mem0", mem[8'h40], 8'h5A);
    check("R6 mem1", mem[8'h41], 8'hC3);

    // R7 bad CRC
    i2c_start; wb(8'h10, 1, "R1"); wb(8'h50, 1, "R7"); wb(8'h77, 1, "R7");
    c = bcrc(bcrc(bcrc(8'h00, 8'h10), 8'h50), 8'h77) ^ 8'h01;
    wb(c, 0, "R7 bad crc");
    wb(8'h66, 0, "R7 ignored");
    i2c_stop;
    check("R7 no write", mem[8'h50], 0);

    // R8 CRC read with repeated start
    i2c_start; wb(8'h10, 1, "R1"); wb(8'h40, 1, "R8");
    i2c_start; wb(8'h11, 1, "R8");
    rb(d, 1); check("R8 data0", d, 8'h5A);
    rb(c, 1); check("R8 crc0", c, bcrc(bcrc(8'h00, 8'h11), 8'h5A));
    rb(d, 1); check("R8 data1", d, 8'hC3);
    rb(c, 0); check("R8 crc1", c, bcrc(8'h00, 8'hC3));
    @(negedge clk) check("R8 released", sda_oe, 0);
    rb(d, 0); check("R8 idle", d, 8'hFF);
    i2c_stop;

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule